// File: doc/BRIEF.md
# Delayed Sync Command Decoder with Local Bunch Clock

This block takes the decoded byte stream from a front-end serial link. Each byte carries an 8-bit value and a flag that marks it as a control (K) character. A sync command is two bytes long. The first is a reserved K character. The second is a data byte that carries a 2-bit command type and a 6-bit delay. When the block decodes a command, it counts the given number of machine clocks and then raises a one-cycle pulse on the output line that belongs to that type.

Type 0 is the train-sync. When its pulse fires, it also restarts a local divide-by-n counter. That counter produces the slow bunch clock, so every receiver that sees the same command at the same latency ends up with its bunch clock in the same phase. The machine clock runs faster than the bunch rate, typically at 50 to 100 MHz. The ratio n comes from a plain control pin.

The byte input is a valid/ready stream. Ready is low while reset is asserted and rises on the first clock edge after reset is released. From then on the block never applies back-pressure, so the upstream decoder may present a byte on every cycle. A byte counts only on an edge where both valid and ready are high. Pulses, the error flag and the bunch clock are plain outputs with no handshake.

Top module: `sync_cmd_rx`

## Requirements
- R1: `in_ready` is low during reset and becomes high on the first clock edge after reset is released. It then stays high, so every byte presented with `in_valid` high is accepted.
- R2: A command starts with an accepted byte that has `in_is_k` = 1 and `in_data` equal to the parameter `SYNC_K` (default 8'h5C). The next accepted byte with `in_is_k` = 0 is the payload. Bits 7:6 of the payload are the type and bits 5:0 are the delay d.
- R3: A payload accepted at clock edge k produces a pulse that is set at edge k+1+d and lasts exactly one cycle. So with d = 0 the pulse appears in the cycle right after the decode.
- R4: The pulse appears only on bit `type` of `cmd_pulse[3:0]`. No two bits of `cmd_pulse` are ever high at once.
- R5: A command whose decode edge (k+1) falls while a countdown with d > 0 is still running is dropped. This includes the edge on which that countdown fires. For a dropped command, `cmd_err` is high for one cycle after the decode edge and no pulse is issued.
- R6: `bunch_clk` has a period of n machine clocks, where n is `div_n`, with values below 2 treated as 2. It is high for the first floor(n/2) counts of each period. Its count is 0 while reset is asserted.
- R7: On the edge that sets `cmd_pulse[0]`, the divider count returns to 0. As a result `bunch_clk` is high in the same cycle as the train-sync pulse, and a new period starts there.
- R8: The following bytes produce no pulse and no error: data bytes outside a command, K characters other than `SYNC_K`, and data bytes equal to `SYNC_K` with the K flag clear. Any K character other than `SYNC_K` that arrives between a header and its payload cancels the pending header. A repeated header simply restarts the command.
- R9: Cycles with `in_valid` low are ignored, including cycles between a header and its payload. The command still decodes when the payload arrives.
- R10: While reset is asserted, `cmd_pulse` and `cmd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | 8 | Decoded byte value |
| in_is_k | input | 1 | Byte is a control character |
| div_n | input | CNT_W (8) | Bunch clock divide ratio |
| cmd_pulse | output | 4 | One-cycle pulse per command type |
| cmd_err | output | 1 | Command dropped because a countdown was busy |
| bunch_clk | output | 1 | Local divided bunch clock |

## Verification
The bench checks the two ends of the delay range: zero, where a design that loads and then waits would emit the pulse one cycle late, and 63, where a short counter would wrap. It places a second command so that it decodes exactly on the edge where a running countdown fires. An off-by-one busy window would then either accept that command or reject the one that follows a cycle later. It presents framing hazards: K characters inside a command, a data byte equal to the header code, and header/payload gaps with valid low. A loose parser would turn any of these into stray pulses. Finally, it changes the divide ratio, including to 0 and 1, around train-syncs, so that a divider reset taken one cycle off or a bad halving of n shows up as a phase or duty error.

// File: rtl/sync_cmd_pkg.sv
package sync_cmd_pkg;
  localparam int KIND_W    = 2;
  localparam int WAIT_W    = 6;
  localparam int NUM_KINDS = 1 << KIND_W;
  localparam int BYTE_W    = 8;
  localparam logic [KIND_W-1:0] KIND_TRAIN = '0;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [WAIT_W-1:0] wait_cnt;
  } sync_cmd_t;
endpackage

// File: rtl/sync_word_detect.sv
module sync_word_detect
  import sync_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SYNC_K = 8'h5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] data,
  input  logic              is_k,
  output logic              cmd_vld,
  output sync_cmd_t         cmd
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      cmd_vld <= 1'b0;
      cmd     <= '0;
    end else begin
      cmd_vld <= 1'b0;
      if (take) begin
        if (is_k && data == SYNC_K) begin
          armed <= 1'b1;
        end else if (armed) begin
          armed <= 1'b0;
          if (!is_k) begin
            cmd_vld <= 1'b1;
            cmd     <= sync_cmd_t'(data);
          end
        end
      end
    end
  end
endmodule

// File: rtl/sync_delay_timer.sv
module sync_delay_timer
  import sync_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_vld,
  input  sync_cmd_t            cmd,
  output logic [NUM_KINDS-1:0] pulse,
  output logic                 err,
  output logic                 train_now
);
  logic              busy;
  logic [WAIT_W-1:0] remain;
  logic [KIND_W-1:0] kind_q;
  logic              fire_late;
  logic              fire_zero;
  logic [KIND_W-1:0] fire_kind;
  logic              fire_any;

  always_comb begin
    fire_late = busy && remain == WAIT_W'(1);
    fire_zero = cmd_vld && !busy && cmd.wait_cnt == '0;
    fire_any  = fire_late || fire_zero;
    fire_kind = fire_late ? kind_q : cmd.kind;
    train_now = fire_any && fire_kind == KIND_TRAIN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
      kind_q <= '0;
      err    <= 1'b0;
    end else begin
      err <= cmd_vld && busy;
      if (busy) begin
        remain <= remain - WAIT_W'(1);
        if (fire_late) busy <= 1'b0;
      end else if (cmd_vld && cmd.wait_cnt != '0) begin
        busy   <= 1'b1;
        remain <= cmd.wait_cnt;
        kind_q <= cmd.kind;
      end
    end
  end

  for (genvar g = 0; g < NUM_KINDS; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[g] <= 1'b0;
      else        pulse[g] <= fire_any && fire_kind == KIND_W'(g);
    end
  end
endmodule

// File: rtl/bunch_divider.sv
module bunch_divider #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] div_n,
  input  logic             realign,
  output logic             slow_clk
);
  localparam logic [CNT_W-1:0] MIN_N = CNT_W'(2);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] eff_n;

  always_comb begin
    eff_n    = (div_n < MIN_N) ? MIN_N : div_n;
    slow_clk = count < (eff_n >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            count <= '0;
    else if (realign)                      count <= '0;
    else if (count >= eff_n - CNT_W'(1))   count <= '0;
    else                                   count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/sync_cmd_rx.sv
module sync_cmd_rx
  import sync_cmd_pkg::*;
#(
  parameter int                CNT_W  = 8,
  parameter logic [BYTE_W-1:0] SYNC_K = 8'h5C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BYTE_W-1:0]    in_data,
  input  logic                 in_is_k,
  input  logic [CNT_W-1:0]     div_n,
  output logic [NUM_KINDS-1:0] cmd_pulse,
  output logic                 cmd_err,
  output logic                 bunch_clk
);
  logic      ready_q;
  logic      dec_vld;
  sync_cmd_t dec_cmd;
  logic      train_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign in_ready = ready_q;

  sync_word_detect #(.SYNC_K(SYNC_K)) u_detect (
    .clk(clk), .rst_n(rst_n), .take(in_valid && ready_q),
    .data(in_data), .is_k(in_is_k), .cmd_vld(dec_vld), .cmd(dec_cmd)
  );

  sync_delay_timer u_timer (
    .clk(clk), .rst_n(rst_n), .cmd_vld(dec_vld), .cmd(dec_cmd),
    .pulse(cmd_pulse), .err(cmd_err), .train_now(train_now)
  );

  bunch_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_n(div_n),
    .realign(train_now), .slow_clk(bunch_clk)
  );
endmodule

// File: rtl/sync_cmd_rx_chk.sv
module sync_cmd_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic [3:0] cmd_pulse,
  input logic       cmd_err,
  input logic       bunch_clk
);
  p_ready_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_ready) |-> in_ready);
  p_pulse_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pulse));
  p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> !cmd_err);
  p_train_aligns_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse[0] |-> bunch_clk);
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (cmd_pulse == 4'b0 && !cmd_err));
endmodule

bind sync_cmd_rx sync_cmd_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .cmd_pulse(cmd_pulse), .cmd_err(cmd_err), .bunch_clk(bunch_clk)
);

// File: tb/sim_sync_cmd_rx.sv
module sim_sync_cmd_rx;
  localparam logic [7:0] HDR = 8'h5C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_is_k = 1'b0;
  logic [7:0] div_n = 8'd8;
  logic [3:0] cmd_pulse;
  logic       cmd_err;
  logic       bunch_clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_cmd_rx u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_is_k(in_is_k), .div_n(div_n),
    .cmd_pulse(cmd_pulse), .cmd_err(cmd_err), .bunch_clk(bunch_clk)
  );

  // behavioural reference state
  int   edge_no = 0;
  bit   m_ready = 0;
  bit   m_armed = 0;
  bit   dec_due = 0;
  int   dec_kind = 0;
  int   dec_wait = 0;
  bit   pend = 0;
  int   pend_edge = 0;
  int   pend_kind = 0;
  logic [3:0] e_pulse = 0;
  bit   e_err = 0;
  int   m_cnt = 0;
  int   pulse_seen = 0;
  int   err_seen = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at edge %0d", tag, act, exp, edge_no);
    end
  endtask

  always @(posedge clk) begin
    bit fire_now;
    bit sync_now;
    int effn;
    if (!rst_n) begin
      m_ready = 0; m_armed = 0; dec_due = 0; pend = 0;
      e_pulse = 0; e_err = 0; m_cnt = 0;
    end else begin
      e_pulse = 0; e_err = 0; sync_now = 0;
      fire_now = pend && pend_edge == edge_no;
      if (fire_now) begin
        e_pulse[pend_kind] = 1'b1;
        sync_now = (pend_kind == 0);
      end
      if (dec_due) begin
        if (pend) e_err = 1;
        else if (dec_wait == 0) begin
          e_pulse[dec_kind] = 1'b1;
          sync_now = (dec_kind == 0);
        end else begin
          pend = 1; pend_edge = edge_no + dec_wait; pend_kind = dec_kind;
        end
      end
      if (fire_now) pend = 0;
      dec_due = 0;
      if (in_valid && m_ready) begin
        if (in_is_k && in_data == HDR) m_armed = 1;
        else if (m_armed) begin
          m_armed = 0;
          if (!in_is_k) begin
            dec_due = 1; dec_kind = int'(in_data[7:6]); dec_wait = int'(in_data[5:0]);
          end
        end
      end
      effn = (div_n < 2) ? 2 : int'(div_n);
      if (sync_now) m_cnt = 0;
      else if (m_cnt >= effn - 1) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      m_ready = 1;
    end
    edge_no++;
    #1;
    begin
      int effc;
      effc = (div_n < 2) ? 2 : int'(div_n);
      check(cmd_pulse == e_pulse, "R3/R4 cmd_pulse", int'(cmd_pulse), int'(e_pulse));
      check(cmd_err == e_err, "R5 cmd_err", int'(cmd_err), int'(e_err));
      check(bunch_clk == (m_cnt < effc / 2), "R6/R7 bunch_clk", int'(bunch_clk), int'(m_cnt < effc / 2));
      check(in_ready == m_ready, "R1 in_ready", int'(in_ready), int'(m_ready));
      if (cmd_pulse != 0) pulse_seen++;
      if (cmd_err) err_seen++;
    end
  end

  task automatic push(input bit k, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_is_k = k; in_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_is_k = 1'b0; in_data = 8'h00;
    end
  endtask

  task automatic send_cmd(input int kind, input int wait_cnt);
    push(1'b1, HDR);
    push(1'b0, {kind[1:0], wait_cnt[5:0]});
  endtask

  initial begin
    int base;
    idle(3);
    // R10: outputs quiet during reset
    check(cmd_pulse == 0 && !cmd_err, "R10 reset outputs", int'(cmd_pulse), 0);
    check(in_ready == 0, "R1 ready low in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    idle(4);

    // R2/R3: delay 0, type 1
    base = pulse_seen;
    send_cmd(1, 0); idle(5);
    check(pulse_seen - base == 1, "R2 zero-delay command decoded", pulse_seen - base, 1);
    send_cmd(2, 5); idle(10);
    send_cmd(3, 63); idle(70);
    // R7 train-sync with n=8, then n=5
    send_cmd(0, 3); idle(20);
    div_n = 8'd5; idle(12);
    send_cmd(0, 2); idle(15);
    // R5: overlap and exact-fire collision
    base = err_seen;
    send_cmd(1, 10); send_cmd(2, 0); idle(15);
    check(err_seen - base == 1, "R5 overlap flagged", err_seen - base, 1);
    send_cmd(1, 2); send_cmd(3, 0); idle(6);
    send_cmd(2, 1); send_cmd(3, 0); idle(6);
    // R8: ignored patterns
    base = pulse_seen;
    push(1'b0, 8'h41); push(1'b0, 8'h02);
    push(1'b1, 8'hBC); push(1'b0, 8'h03);
    push(1'b0, HDR); push(1'b0, 8'h00);
    push(1'b1, HDR); push(1'b1, 8'hBC); push(1'b0, 8'h40);
    idle(6);
    check(pulse_seen == base, "R8 stray bytes ignored", pulse_seen - base, 0);
    // R8: repeated header restarts
    base = pulse_seen;
    push(1'b1, HDR); push(1'b1, HDR); push(1'b0, 8'h81); idle(5);
    check(pulse_seen - base == 1, "R8 repeated header", pulse_seen - base, 1);
    // R9: gap between header and payload
    base = pulse_seen;
    push(1'b1, HDR); idle(3); push(1'b0, 8'hC4); idle(8);
    check(pulse_seen - base == 1, "R9 gap tolerated", pulse_seen - base, 1);
    // R6: n below 2
    div_n = 8'd1; idle(6);
    div_n = 8'd0; send_cmd(0, 1); idle(6);
    div_n = 8'd7; send_cmd(0, 0); idle(16);
    // R10: reset mid-countdown
    send_cmd(2, 20); idle(3);
    rst_n = 1'b0; idle(2);
    check(cmd_pulse == 0 && !cmd_err, "R10 reset mid countdown", int'(cmd_pulse), 0);
    rst_n = 1'b1; idle(30);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule